// File: doc/BRIEF.md
# Serial Register Port with Readback

This block is the configuration port of a larger chip. A host drives a slow three-wire link made of a serial clock, a data line and a latch strobe. Each 32-bit frame carries its own destination in its low five bits. The block samples all three wires into the fast system clock domain, shifts the data least significant bit first, and on the rising edge of the latch strobe writes the frame into one of eight configuration registers. The contents of every register are driven out in parallel for the rest of the chip.

A command written to register 0 can also arm a read. The block then captures the word that was asked for. After the host sends one idle serial clock, the block returns that word on a dedicated readback wire, one bit per rising serial clock edge, least significant bit first, so the host can sample it on the falling edge. Asking for register 0 does not return the stored command. It returns a status word built from a measurement input, an error flag and a fixed identity code. A start bit in register 2 issues a one-cycle pulse and never stays set.

Top module: `srif_top`

## Requirements
- R1: After reset all eight registers read as zero on `cfg_regs`, and both `rdbk_out` and `cal_start` are low.
- R2: Frame bits are taken on rising `ser_clk` edges, the first bit taken being bit 0. A frame whose bits 4..3 equal 2'b01 is stored whole into register number bits 2..0, so addresses 8 to 15 map to registers 0 to 7. Register n appears on `cfg_regs[32n+31:32n]`.
- R3: A frame whose bits 4..3 differ from 2'b01 changes no register.
- R4: A write changes only the addressed register. All others keep their values.
- R5: If more than 32 bits are shifted before the strobe, the last 32 bits shifted form the frame.
- R6: Writing register 2 with bit 31 set gives exactly one single-cycle pulse on `cal_start`. Stored bit 31 of register 2 always reads 0, and the other bits are stored as written.
- R7: A register-0 write with bit 31 set arms a readback of the register numbered by bits 30..28. A register-0 write with bit 31 clear arms nothing, and `rdbk_out` stays low.
- R8: After the arming strobe, the first rising `ser_clk` edge is idle and `rdbk_out` stays low. Rising edges 2 to 33 drive word bits 0 to 31 in turn. From edge 34 onward `rdbk_out` is low.
- R9: A readback of register 0 returns this word: bit 31 is bit 27 of the arming command, bits 30..13 are `cnt_val`, bit 12 is `cal_err` (both taken when the command is committed), bits 6..5 are 2'b11, and every other bit is 0.
- R10: The strobe acts on its own rising edge. No `ser_clk` edge is needed after it for the write to take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| ser_dat | input | 1 | Host serial data, asynchronous |
| ser_le | input | 1 | Host latch strobe, asynchronous |
| cnt_val | input | 18 | Measurement value reported in the register-0 readback word |
| cal_err | input | 1 | Error flag reported in the register-0 readback word |
| rdbk_out | output | 1 | Serial readback data |
| cal_start | output | 1 | One-cycle pulse when the start bit of register 2 is written |
| cfg_regs | output | 256 | All eight registers, register n in bits 32n+31..32n |

## Verification
The assertions assume that the three host wires change slowly compared with the system clock. Each level must stay stable for several system clocks, so that every serial edge shows up as exactly one detected pulse and the data bit is settled when that pulse arrives. The stimulus keeps every serial half period at six system clocks. It changes data only while the serial clock is low, and it raises the strobe only while the serial clock is low. During a readback the data line is held low and no strobe is sent, so the armed word is never interrupted.

// File: rtl/srif_pkg.sv
package srif_pkg;
    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_WAIT  = 2'd1,
        RB_SHIFT = 2'd2
    } rb_state_e;
endpackage

// File: rtl/srif_sync.sv
module srif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = {sy_q.chain[STAGES-2:0], din};
        sy_d.prev  = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign level = sy_q.chain[STAGES-1];
    assign rise  = sy_q.chain[STAGES-1] & ~sy_q.prev;
endmodule

// File: rtl/srif_shift_in.sv
module srif_shift_in #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] frame
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {bit_in, sh_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame = sh_q;

    // R2
    shift_lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sh_q[W-1] == $past(bit_in)));
endmodule

// File: rtl/srif_regbank.sv
module srif_regbank #(
    parameter int NREG     = 8,
    parameter int W        = 32,
    parameter int ADDR_W   = 5,
    parameter int BANK_TAG = 1,
    parameter int CAL_REG  = 2,
    parameter int CAL_BIT  = 31,
    localparam int IDX_W   = $clog2(NREG),
    localparam int TAG_W   = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [W-1:0]      frame,
    output logic [NREG*W-1:0] regs_flat,
    output logic              wr_hit,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              cal_start
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
        logic                   cal;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [IDX_W-1:0] idx;
    logic             hit;

    assign idx = frame[IDX_W-1:0];
    assign hit = (frame[ADDR_W-1:IDX_W] == TAG_W'(BANK_TAG));

    always_comb begin
        bk_d     = bk_q;
        bk_d.cal = 1'b0;
        if (commit && hit) begin
            bk_d.regs[idx] = frame;
            if (idx == IDX_W'(CAL_REG)) begin
                bk_d.regs[idx][CAL_BIT] = 1'b0;
                bk_d.cal                = frame[CAL_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign regs_flat = bk_q.regs;
    assign wr_hit    = commit && hit;
    assign wr_idx    = idx;
    assign cal_start = bk_q.cal;

    // R6
    cal_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R6
    cal_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && hit && idx == IDX_W'(CAL_REG)) |=> !regs_flat[CAL_REG*W + CAL_BIT]);

    // R3
    bad_addr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !hit) |=> $stable(regs_flat));
endmodule

// File: rtl/srif_rdbk.sv
module srif_rdbk
    import srif_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int W       = 32,
    parameter int CNT_W   = 18,
    parameter int CNT_LSB = 13,
    parameter int ERR_BIT = 12,
    parameter int ID_LSB  = 5,
    parameter int ID_W    = 2,
    parameter int CHIP_ID = 3,
    localparam int IDX_W  = $clog2(NREG),
    localparam int CW     = $clog2(W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [IDX_W-1:0]  sel,
    input  logic              cnt_sel,
    input  logic [NREG*W-1:0] regs_flat,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cal_err,
    input  logic              sclk_rise,
    output logic              rdbk_out
);
    typedef struct packed {
        rb_state_e     state;
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          out;
    } rb_t;

    rb_t rb_d, rb_q;

    logic [W-1:0] stat_word;
    logic [W-1:0] pick_word;

    always_comb begin
        stat_word                    = '0;
        stat_word[W-1]               = cnt_sel;
        stat_word[CNT_LSB +: CNT_W]  = cnt_val;
        stat_word[ERR_BIT]           = cal_err;
        stat_word[ID_LSB +: ID_W]    = ID_W'(CHIP_ID);
        pick_word = regs_flat[int'(sel)*W +: W];
        if (sel == '0) pick_word = stat_word;
    end

    always_comb begin
        rb_d = rb_q;
        if (arm) begin
            rb_d.state = RB_WAIT;
            rb_d.word  = pick_word;
            rb_d.cnt   = '0;
            rb_d.out   = 1'b0;
        end else begin
            case (rb_q.state)
                RB_WAIT: begin
                    if (sclk_rise) rb_d.state = RB_SHIFT;
                end
                RB_SHIFT: begin
                    if (sclk_rise) begin
                        if (rb_q.cnt == CW'(W)) begin
                            rb_d.state = RB_IDLE;
                            rb_d.out   = 1'b0;
                        end else begin
                            rb_d.out  = rb_q.word[0];
                            rb_d.word = {1'b0, rb_q.word[W-1:1]};
                            rb_d.cnt  = rb_q.cnt + 1'b1;
                        end
                    end
                end
                default: rb_d.out = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '{state: RB_IDLE, word: '0, cnt: '0, out: 1'b0};
        else        rb_q <= rb_d;
    end

    assign rdbk_out = rb_q.out;

    // R7
    arm_starts_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (rb_q.state == RB_WAIT));

    // R8
    idle_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.state == RB_WAIT) |-> !rdbk_out);

    // R8
    done_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.state == RB_IDLE) |-> !rdbk_out);
endmodule

// File: rtl/srif_top.sv
module srif_top #(
    parameter int NREG        = 8,
    parameter int W           = 32,
    parameter int ADDR_W      = 5,
    parameter int BANK_TAG    = 1,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 18,
    parameter int CNT_LSB     = 13,
    parameter int ERR_BIT     = 12,
    parameter int ID_LSB      = 5,
    parameter int ID_W        = 2,
    parameter int CHIP_ID     = 3,
    parameter int RB_EN_BIT   = 31,
    parameter int RB_SEL_LSB  = 28,
    parameter int CNT_SEL_BIT = 27,
    parameter int CAL_REG     = 2,
    parameter int CAL_BIT     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cal_err,
    output logic              rdbk_out,
    output logic              cal_start,
    output logic [NREG*W-1:0] cfg_regs
);
    localparam int IDX_W = $clog2(NREG);
    localparam int NPIN  = 3;

    logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise;
    assign pin_raw = {ser_le, ser_dat, ser_clk};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        srif_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pin_raw[g]),
            .level (pin_lvl[g]),
            .rise  (pin_rise[g])
        );
    end

    logic unused_pins;
    assign unused_pins = pin_lvl[0] ^ pin_lvl[2] ^ pin_rise[1];

    logic [W-1:0]     frame;
    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;
    logic             rb_arm;

    srif_shift_in #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pin_rise[0]),
        .bit_in   (pin_lvl[1]),
        .frame    (frame)
    );

    srif_regbank #(
        .NREG(NREG), .W(W), .ADDR_W(ADDR_W), .BANK_TAG(BANK_TAG),
        .CAL_REG(CAL_REG), .CAL_BIT(CAL_BIT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (pin_rise[2]),
        .frame     (frame),
        .regs_flat (cfg_regs),
        .wr_hit    (wr_hit),
        .wr_idx    (wr_idx),
        .cal_start (cal_start)
    );

    assign rb_arm = wr_hit && (wr_idx == '0) && frame[RB_EN_BIT];

    srif_rdbk #(
        .NREG(NREG), .W(W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
        .ERR_BIT(ERR_BIT), .ID_LSB(ID_LSB), .ID_W(ID_W), .CHIP_ID(CHIP_ID)
    ) u_rdbk (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (rb_arm),
        .sel       (frame[RB_SEL_LSB +: IDX_W]),
        .cnt_sel   (frame[CNT_SEL_BIT]),
        .regs_flat (cfg_regs),
        .cnt_val   (cnt_val),
        .cal_err   (cal_err),
        .sclk_rise (pin_rise[0]),
        .rdbk_out  (rdbk_out)
    );
endmodule

// File: tb/sim_srif_top.sv
module sim_srif_top;
    localparam int W = 32;
    localparam int NREG = 8;
    localparam int HALF = 6;
    localparam int NVEC = 11;
    localparam logic [W-1:0] VEC [NVEC] = '{
        32'h1357_9B09, 32'hDEAD_BE0B, 32'h0F0F_F00F, 32'hFFFF_FF01,
        32'h2468_AC0C, 32'h7777_771A, 32'hC0FF_EE0D, 32'h4000_0008,
        32'h3000_0010, 32'h5555_AA0E, 32'h0123_450F
    };

    logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_le = 0;
    logic [17:0] cnt_val = '0;
    logic cal_err = 0;
    wire rdbk_out, cal_start;
    wire [NREG*W-1:0] cfg_regs;

    srif_top u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .cnt_val(cnt_val), .cal_err(cal_err),
        .rdbk_out(rdbk_out), .cal_start(cal_start), .cfg_regs(cfg_regs)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cal_cnt = 0;
    bit done = 0;
    logic [W-1:0] model [NREG];

    always @(negedge clk) if (cal_start) cal_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = v[i];
            tick(HALF); ser_clk = 1;
            tick(HALF); ser_clk = 0;
        end
        ser_dat = 0;
        tick(HALF); ser_le = 1;
        tick(HALF); ser_le = 0;
        tick(4);
    endtask

    task automatic model_put(input logic [W-1:0] f);
        if (f[4:3] == 2'b01) begin
            model[f[2:0]] = f;
            if (f[2:0] == 3'd2) model[2][31] = 1'b0;
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk($sformatf("%s reg%0d", tag, i), cfg_regs[i*W +: W], model[i]);
    endtask

    task automatic run_rb(input string tag, input logic [W-1:0] exp);
        logic [W-1:0] got;
        got = '0;
        for (int k = 1; k <= 34; k++) begin
            tick(HALF); ser_clk = 1;
            tick(HALF);
            if (k == 1) chk("R8 idle edge", {31'b0, rdbk_out}, 32'h0);
            else if (k <= 33) got[k-2] = rdbk_out;
            else chk("R8 after word", {31'b0, rdbk_out}, 32'h0);
            ser_clk = 0;
        end
        chk(tag, got, exp);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        tick(5);
        // R1 reset state
        check_bank("R1");
        chk("R1 rdbk_out", {31'b0, rdbk_out}, 32'h0);
        chk("R1 cal_start", {31'b0, cal_start}, 32'h0);
        rst_n = 1;
        tick(3);

        // table walk: R2 R3 R4 R10
        for (int v = 0; v < NVEC; v++) begin
            send_bits({32'h0, VEC[v]}, W);
            model_put(VEC[v]);
            if (VEC[v][4:3] == 2'b01) check_bank($sformatf("R2/R4/R10 vec%0d", v));
            else check_bank($sformatf("R3 vec%0d", v));
        end

        // R5 overlong frame: last 32 bits land in reg6
        send_bits({24'h0, 32'h1234_560E, 8'hA7}, 40);
        model_put(32'h1234_560E);
        check_bank("R5");

        // R6 start bit in register 2
        begin
            int c0;
            c0 = cal_cnt;
            send_bits({32'h0, 32'h8ABC_DE0A}, W);
            model_put(32'h8ABC_DE0A);
            chk("R6 pulse count", cal_cnt - c0, 1);
            check_bank("R6");
        end

        // R7 R8 readback of register 5
        send_bits({32'h0, 32'hD000_0008}, W);
        model_put(32'hD000_0008);
        run_rb("R7 read reg5", model[5]);

        // R7 readback of register 2 (start bit reads 0)
        send_bits({32'h0, 32'hA000_0008}, W);
        model_put(32'hA000_0008);
        run_rb("R7 read reg2", model[2]);

        // R9 status word, counter select set, error set
        cnt_val = 18'h2_B3C5; cal_err = 1;
        send_bits({32'h0, 32'h8800_0008}, W);
        model_put(32'h8800_0008);
        cnt_val = 18'h0_0000; cal_err = 0;
        run_rb("R9 status a", {1'b1, 18'h2_B3C5, 1'b1, 5'b0, 2'b11, 5'b0});

        // R9 status word, counter select clear
        cnt_val = 18'h0_0F0F; cal_err = 0;
        send_bits({32'h0, 32'h8000_0008}, W);
        model_put(32'h8000_0008);
        run_rb("R9 status b", {1'b0, 18'h0_0F0F, 1'b0, 5'b0, 2'b11, 5'b0});

        // R7 register-0 write without enable arms nothing
        begin
            int ones;
            ones = 0;
            send_bits({32'h0, 32'h5000_0008}, W);
            model_put(32'h5000_0008);
            for (int k = 0; k < 34; k++) begin
                tick(HALF); ser_clk = 1;
                tick(HALF); if (rdbk_out) ones++;
                ser_clk = 0;
            end
            chk("R7 no arm", ones, 0);
            check_bank("R7 bank");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule